// File: doc/BRIEF.md
# Multi-Phase Reset Sequencer

This block steps a chip through its reset sequence. There are four held-reset phases, numbered 0 to 3, and a final Idle phase in which the system is released. The block runs on the clock of the internal oscillator. Reset requests arrive as level lines from three classes of source: destructive, external and functional. Each source has an enable bit. Each functional source also has a bit that selects the short sequence.

Each class re-enters the sequence at its own point:

- A destructive request sends the block back to phase 0.
- An external request, or a functional request set for the long sequence, sends it to phase 1.
- A functional request set for the short sequence, raised in Idle, sends it to phase 3.

A request line is treated as a pending event for as long as it stays high. Each phase has a minimum dwell. A single saturating counter times the dwell. The counter clears when the block enters a phase, and also on every cycle in which a qualifying event is pending.

The oscillator-stable, regulator-OK and flash-init-done inputs come from other blocks and are used as plain status levels. The block asks for flash initialization with a one-cycle pulse when it enters phase 2 and again when it enters phase 3.

Top module: `rst_phase_seq`

## Requirements
- R1: While `rst_ni` is low and just after it rises, `phase_o` is 0, `sys_rst_o` is 1, `release_o` is 0 and `flash_req_o` is 0. Phase codes are 0 to 3 for phases 0 to 3 and 4 for Idle; no other value appears.
- R2: Phase 0 is held while `osc_stable_i` or `vreg_ok_i` is low, or while an enabled destructive event is pending. Once all three conditions are met, the block moves to phase 1 on the 4th clock edge (T0=3).
- R3: An enabled destructive event (`dest_evt_i[i]` and `dest_en_i[i]` both 1) moves the block to phase 0 at the next edge, from any phase. It has priority over every other event.
- R4: An enabled long event moves phase 2, phase 3 or Idle to phase 1 at the next edge. A long event is `ext_evt_i[i]&ext_en_i[i]`, or `func_evt_i[i]&func_en_i[i]` with `func_short_i[i]`=0. A long event beats a short event raised in the same cycle.
- R5: Phase 1 moves to phase 2 on the 351st edge after the later of phase-1 entry and the last cycle with a long event pending (T1=350). A new long event restarts this count.
- R6: Phase 2 is entered only from phase 1. It moves to phase 3 no sooner than the 9th edge after entry (T2=8), and only while `flash_done_i` is 1. It is held for as long as `flash_done_i` is low.
- R7: An enabled short functional event (`func_short_i[i]`=1) in Idle moves the block to phase 3 at the next edge. In phase 3 such an event restarts the dwell count. In phases 0, 1 and 2 it has no effect.
- R8: Phase 3 moves to Idle on the 41st edge after the later of phase-3 entry and the last short event (T3=40), provided `flash_done_i` is 1.
- R9: `flash_req_o` is high for exactly the first cycle of each stay in phase 2 and each stay in phase 3, and is low at all other times.
- R10: `sys_rst_o` is 1 in every phase except Idle. `release_o` is 1 only in Idle.
- R11: A request line whose enable bit is 0 causes no phase change and does not restart any dwell count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| dest_evt_i | input | N_DEST | Destructive reset request lines |
| dest_en_i | input | N_DEST | Per-source destructive enable |
| ext_evt_i | input | N_EXT | External reset request lines |
| ext_en_i | input | N_EXT | Per-source external unmask |
| func_evt_i | input | N_FUNC | Functional reset request lines |
| func_en_i | input | N_FUNC | Per-source functional enable |
| func_short_i | input | N_FUNC | Per-source short-sequence select |
| osc_stable_i | input | 1 | Oscillator running and stable |
| vreg_ok_i | input | 1 | Regulator voltage good |
| flash_done_i | input | 1 | Flash initialization complete |
| phase_o | output | 3 | Current phase code |
| sys_rst_o | output | 1 | System held in reset |
| flash_req_o | output | 1 | Flash initialization request pulse |
| release_o | output | 1 | System released to the platform |

## Verification
Full sequences run from power-on with every status input good, and then with each status input held low. Comparing the two shows whether a phase exits on its dwell count alone or also waits on its status condition. One-cycle events are injected while the block sits in Idle, covering every class with its enable both set and cleared, and with two classes raised together. These runs separate the three re-entry points from each other, from a masked no-op, and from priority errors. Events raised part-way through phases 1 and 3 test whether the count restarts: an exact edge count of T+1 after the last event tells a true restart apart from a count measured from phase entry. A disabled event mid-phase checks the opposite case, where the count must not restart.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [2:0] {
    PH0     = 3'd0,
    PH1     = 3'd1,
    PH2     = 3'd2,
    PH3     = 3'd3,
    PH_IDLE = 3'd4
  } phase_e;
endpackage

// File: rtl/rsq_evt_qual.sv
module rsq_evt_qual #(
  parameter int N_DEST = 2,
  parameter int N_EXT  = 2,
  parameter int N_FUNC = 3
) (
  input  logic [N_DEST-1:0] dest_evt_i,
  input  logic [N_DEST-1:0] dest_en_i,
  input  logic [N_EXT-1:0]  ext_evt_i,
  input  logic [N_EXT-1:0]  ext_en_i,
  input  logic [N_FUNC-1:0] func_evt_i,
  input  logic [N_FUNC-1:0] func_en_i,
  input  logic [N_FUNC-1:0] func_short_i,
  output logic              dest_act_o,
  output logic              long_act_o,
  output logic              short_act_o
);
  logic [N_FUNC-1:0] func_long;
  logic [N_FUNC-1:0] func_shrt;

  for (genvar i = 0; i < N_FUNC; i++) begin : g_func
    assign func_long[i] = func_evt_i[i] & func_en_i[i] & ~func_short_i[i];
    assign func_shrt[i] = func_evt_i[i] & func_en_i[i] &  func_short_i[i];
  end

  assign dest_act_o  = |(dest_evt_i & dest_en_i);
  assign long_act_o  = |(ext_evt_i & ext_en_i) | (|func_long);
  assign short_act_o = |func_shrt;
endmodule

// File: rtl/rsq_dwell_cnt.sv
module rsq_dwell_cnt #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_o <= '0;
    else if (clr_i)            cnt_o <= '0;
    else if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rsq_phase_fsm.sv
module rsq_phase_fsm
  import rsq_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int T0    = 3,
  parameter int T1    = 350,
  parameter int T2    = 8,
  parameter int T3    = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dest_act_i,
  input  logic             long_act_i,
  input  logic             short_act_i,
  input  logic             osc_stable_i,
  input  logic             vreg_ok_i,
  input  logic             flash_done_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             clr_o,
  output phase_e           phase_o,
  output logic             flash_req_o
);
  localparam logic [CNT_W-1:0] LIM0 = CNT_W'(T0);
  localparam logic [CNT_W-1:0] LIM1 = CNT_W'(T1);
  localparam logic [CNT_W-1:0] LIM2 = CNT_W'(T2);
  localparam logic [CNT_W-1:0] LIM3 = CNT_W'(T3);

  phase_e phase_q, phase_d;
  logic   restart;

  always_comb begin
    phase_d = phase_q;
    restart = 1'b0;
    if (dest_act_i) begin
      phase_d = PH0;
      restart = 1'b1;
    end else begin
      unique case (phase_q)
        PH0: begin
          if (!(osc_stable_i && vreg_ok_i)) restart = 1'b1;
          else if (cnt_i >= LIM0)          phase_d = PH1;
        end
        PH1: begin
          if (long_act_i)          restart = 1'b1;
          else if (cnt_i >= LIM1)  phase_d = PH2;
        end
        PH2: begin
          if (long_act_i)                          phase_d = PH1;
          else if (flash_done_i && cnt_i >= LIM2)  phase_d = PH3;
        end
        PH3: begin
          if (long_act_i)                          phase_d = PH1;
          else if (short_act_i)                    restart = 1'b1;
          else if (flash_done_i && cnt_i >= LIM3)  phase_d = PH_IDLE;
        end
        PH_IDLE: begin
          if (long_act_i)       phase_d = PH1;
          else if (short_act_i) phase_d = PH3;
        end
        default: phase_d = PH0;
      endcase
    end
  end

  assign clr_o = restart | (phase_d != phase_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH0;
      flash_req_o <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      flash_req_o <= (phase_d != phase_q) && (phase_d == PH2 || phase_d == PH3);
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/rst_phase_seq.sv
module rst_phase_seq
  import rsq_pkg::*;
#(
  parameter int N_DEST = 2,
  parameter int N_EXT  = 2,
  parameter int N_FUNC = 3,
  parameter int T0     = 3,
  parameter int T1     = 350,
  parameter int T2     = 8,
  parameter int T3     = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_DEST-1:0] dest_evt_i,
  input  logic [N_DEST-1:0] dest_en_i,
  input  logic [N_EXT-1:0]  ext_evt_i,
  input  logic [N_EXT-1:0]  ext_en_i,
  input  logic [N_FUNC-1:0] func_evt_i,
  input  logic [N_FUNC-1:0] func_en_i,
  input  logic [N_FUNC-1:0] func_short_i,
  input  logic              osc_stable_i,
  input  logic              vreg_ok_i,
  input  logic              flash_done_i,
  output logic [2:0]        phase_o,
  output logic              sys_rst_o,
  output logic              flash_req_o,
  output logic              release_o
);
  localparam int T_A   = (T0 > T1) ? T0 : T1;
  localparam int T_B   = (T2 > T3) ? T2 : T3;
  localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic             dest_act, long_act, short_act;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt;
  phase_e           phase;

  rsq_evt_qual #(.N_DEST(N_DEST), .N_EXT(N_EXT), .N_FUNC(N_FUNC)) u_qual (
    .dest_evt_i  (dest_evt_i),
    .dest_en_i   (dest_en_i),
    .ext_evt_i   (ext_evt_i),
    .ext_en_i    (ext_en_i),
    .func_evt_i  (func_evt_i),
    .func_en_i   (func_en_i),
    .func_short_i(func_short_i),
    .dest_act_o  (dest_act),
    .long_act_o  (long_act),
    .short_act_o (short_act)
  );

  rsq_dwell_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .cnt_o (cnt)
  );

  rsq_phase_fsm #(.CNT_W(CNT_W), .T0(T0), .T1(T1), .T2(T2), .T3(T3)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dest_act_i  (dest_act),
    .long_act_i  (long_act),
    .short_act_i (short_act),
    .osc_stable_i(osc_stable_i),
    .vreg_ok_i   (vreg_ok_i),
    .flash_done_i(flash_done_i),
    .cnt_i       (cnt),
    .clr_o       (cnt_clr),
    .phase_o     (phase),
    .flash_req_o (flash_req_o)
  );

  assign phase_o   = phase;
  assign sys_rst_o = (phase != PH_IDLE);
  assign release_o = (phase == PH_IDLE);
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int N_DEST = 2,
  parameter int N_EXT  = 2,
  parameter int N_FUNC = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_DEST-1:0] dest_evt_i,
  input logic [N_DEST-1:0] dest_en_i,
  input logic [N_EXT-1:0]  ext_evt_i,
  input logic [N_EXT-1:0]  ext_en_i,
  input logic [N_FUNC-1:0] func_evt_i,
  input logic [N_FUNC-1:0] func_en_i,
  input logic [N_FUNC-1:0] func_short_i,
  input logic [2:0]        phase_o,
  input logic              sys_rst_o,
  input logic              flash_req_o,
  input logic              release_o
);
  logic dest_req, long_req;
  assign dest_req = |(dest_evt_i & dest_en_i);
  assign long_req = |(ext_evt_i & ext_en_i) | |(func_evt_i & func_en_i & ~func_short_i);

  // R1
  phase_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o <= 3'd4);
  // R10
  release_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |-> (phase_o == 3'd4) && !sys_rst_o);
  // R10
  held_not_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 3'd4) |-> sys_rst_o && !release_o);
  // R3
  dest_to_p0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dest_req |=> phase_o == 3'd0);
  // R4
  long_to_p1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dest_req && long_req && phase_o >= 3'd2) |=> phase_o == 3'd1);
  // R5
  p1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd1 && long_req) |=> phase_o != 3'd2);
  // R6
  p2_from_p1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd2 && $past(phase_o) != 3'd2) |-> $past(phase_o) == 3'd1);
  // R9
  flash_req_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_req_o |-> (phase_o == 3'd2 || phase_o == 3'd3) && phase_o != $past(phase_o));
endmodule

bind rst_phase_seq rsq_checker #(.N_DEST(N_DEST), .N_EXT(N_EXT), .N_FUNC(N_FUNC)) u_rsq_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dest_evt_i  (dest_evt_i),
  .dest_en_i   (dest_en_i),
  .ext_evt_i   (ext_evt_i),
  .ext_en_i    (ext_en_i),
  .func_evt_i  (func_evt_i),
  .func_en_i   (func_en_i),
  .func_short_i(func_short_i),
  .phase_o     (phase_o),
  .sys_rst_o   (sys_rst_o),
  .flash_req_o (flash_req_o),
  .release_o   (release_o)
);

// File: tb/rst_phase_seq_bench.sv
`timescale 1ns/1ps
module rst_phase_seq_bench;
  localparam int ND = 2, NE = 2, NF = 3;
  localparam logic [2:0] P0 = 3'd0, P1 = 3'd1, P2 = 3'd2, P3 = 3'd3, PI = 3'd4;

  // {dest, dest_en, ext, ext_en, func, func_en, func_short, expected phase}
  localparam int NV = 11;
  localparam logic [9:0] VEC [NV] = '{
    {7'b1100000, P0},
    {7'b1000000, PI},
    {7'b0011000, P1},
    {7'b0010000, PI},
    {7'b0000110, P1},
    {7'b0000111, P3},
    {7'b0000101, PI},
    {7'b0000100, PI},
    {7'b1111000, P0},
    {7'b0011111, P1},
    {7'b0100011, PI}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [ND-1:0] dest_evt_i = '0, dest_en_i = '0;
  logic [NE-1:0] ext_evt_i = '0, ext_en_i = '0;
  logic [NF-1:0] func_evt_i = '0, func_en_i = '0, func_short_i = '0;
  logic osc_stable_i = 1'b0, vreg_ok_i = 1'b1, flash_done_i = 1'b1;
  logic [2:0] phase_o;
  logic sys_rst_o, flash_req_o, release_o;

  int n_run = 0, n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  rst_phase_seq #(.N_DEST(ND), .N_EXT(NE), .N_FUNC(NF)) u_rst_phase_seq (
    .clk_i, .rst_ni, .dest_evt_i, .dest_en_i, .ext_evt_i, .ext_en_i,
    .func_evt_i, .func_en_i, .func_short_i, .osc_stable_i, .vreg_ok_i,
    .flash_done_i, .phase_o, .sys_rst_o, .flash_req_o, .release_o
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk_i); @(negedge clk_i); end
  endtask

  task automatic wait_ph(input logic [2:0] p, input int lim, output int n);
    n = 0;
    while (phase_o != p && n < lim) begin
      @(posedge clk_i); @(negedge clk_i); n++;
    end
  endtask

  task automatic clear_evts();
    dest_evt_i = '0; dest_en_i = '0; ext_evt_i = '0; ext_en_i = '0;
    func_evt_i = '0; func_en_i = '0; func_short_i = '0;
  endtask

  // one-cycle pulse, called at a negedge, returns at the next negedge
  task automatic pulse(input logic [6:0] v);
    dest_evt_i[0] = v[6]; dest_en_i[0] = v[5];
    ext_evt_i[1]  = v[4]; ext_en_i[1]  = v[3];
    func_evt_i[1] = v[2]; func_en_i[1] = v[1]; func_short_i[1] = v[0];
    step(1);
    clear_evts();
  endtask

  function automatic string tag_of(input logic [2:0] p);
    case (p)
      P0: return "R3";
      P1: return "R4";
      P3: return "R7";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 phase", phase_o, 0);
    check("R1 sys_rst", sys_rst_o, 1);
    check("R1 release", release_o, 0);
    check("R1 flash_req", flash_req_o, 0);
    rst_ni = 1'b1;
    step(20);
    check("R2 held without osc", phase_o, 0);
    osc_stable_i = 1'b1;
    wait_ph(P1, 50, n);
    check("R2 p0 dwell", n, 4);
    wait_ph(P2, 1000, n);
    check("R5 p1 dwell", n, 351);
    check("R9 req at p2", flash_req_o, 1);
    flash_done_i = 1'b0;
    step(1);
    check("R9 req one cycle", flash_req_o, 0);
    pulse(7'b0000111);
    step(18);
    check("R6 held without done / R7 short ignored in p2", phase_o, 2);
    flash_done_i = 1'b1;
    wait_ph(P3, 50, n);
    check("R6 exit when done", n, 1);
    check("R9 req at p3", flash_req_o, 1);
    wait_ph(PI, 100, n);
    check("R8 p3 dwell", n, 41);
    check("R10 sys_rst idle", sys_rst_o, 0);
    check("R10 release idle", release_o, 1);
    // short from idle, then restart in p3
    pulse(7'b0000111);
    check("R7 short to p3", phase_o, 3);
    step(20);
    pulse(7'b0000111);
    wait_ph(PI, 100, n);
    check("R7 p3 restart", n, 41);
    // long from idle, masked event mid p1
    pulse(7'b0011000);
    check("R4 ext to p1", phase_o, 1);
    step(100);
    pulse(7'b0010000);
    wait_ph(P2, 1000, n);
    check("R11 masked no restart", n, 250);
    pulse(7'b1100000);
    check("R3 dest in p2", phase_o, 0);
    wait_ph(P1, 50, n);
    check("R2 p0 after dest", n, 4);
    step(200);
    pulse(7'b0011000);
    wait_ph(P2, 1000, n);
    check("R5 p1 restart", n, 351);
    // held destructive request
    dest_evt_i[1] = 1'b1; dest_en_i[1] = 1'b1;
    step(10);
    check("R3 held dest", phase_o, 0);
    clear_evts();
    wait_ph(P1, 50, n);
    check("R2 exit after dest drop", n, 4);
    // vector table from Idle
    for (int i = 0; i < NV; i++) begin
      wait_ph(PI, 2000, n);
      check("R8 reach idle", phase_o, 4);
      pulse(VEC[i][9:3]);
      check(tag_of(VEC[i][2:0]), phase_o, VEC[i][2:0]);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule